// File: doc/BRIEF.md
# Indexed Host Register Bank

This block is a small control register file that a host reaches through a narrow I/O window. It does not map each register to its own address. The host first writes an 8-bit register number to the index port. It then reads or writes the chosen register through the data port, as a full 16-bit word or as a single byte. The index is kept after each data access, so a run of data accesses all reach the same register until the host writes a new index. Two read-only status ports in the same window pass through DMA status and link status from the rest of the chip.

Two host functions decode into this window and share one physical register set. Whatever one function writes, the other function reads back. Each register slot is given a kind by parameter:

- read/write storage;
- read-only, which mirrors a hardware value;
- write-only, whose stored value reaches the chip but reads back as zero.

A per-bit mask sets which bits of a slot exist. A per-bit sticky mask sets which bits keep their value through a bus reset while auxiliary power is present. Indices outside the implemented range read as zero and ignore writes. The stored contents of all slots go to the rest of the chip on `ctrl_q`.

Top module: `idx_reg_bank`

## Requirements
- R1: During and after a bus reset taken with `aux_pwr` low, the index register is 00h and every stored bit on `ctrl_q` is zero.
- R2: A write to window offset 2h loads `wdata[7:0]` into the index register. A 16-bit read at offset 2h returns `{8'h00, index}`.
- R3: A 16-bit access at data offset 0h (or 1h) reads or writes all 16 bits of the selected register, limited to the bits that the register implements.
- R4: An 8-bit data access uses `acc_addr[0]` as the byte lane (0 = bits 7:0, 1 = bits 15:8). A write takes `wdata[7:0]` and changes only that byte. A read returns that byte in `rdata[7:0]`, with `rdata[15:8]` zero.
- R5: Data-port accesses leave the index unchanged, so consecutive data accesses target the same register.
- R6: A 16-bit read at offset 4h returns `dma_status`, and a 16-bit read at offset Ch returns `link_status`. Writes to those offsets do not change any register. Offsets 3h, 5h–Bh, Dh–Fh read as zero.
- R7: Indices below 10h and indices from 14h upward (the default bank is 10h–13h) read as zero through the data port, and writes to them change nothing on `ctrl_q`.
- R8: In the register at index 10h, bits 2:0 always read zero and ignore writes. Bits 15:3 are storage.
- R9: The register at index 12h is read-only. It reads `hw_val[47:32]`, ignores writes, and shows zero on `ctrl_q[47:32]`.
- R10: The register at index 13h is write-only. It reads as zero, and its written value appears on `ctrl_q[63:48]`.
- R11: Bits 15:8 of the register at index 11h are sticky. A bus reset with `aux_pwr` high keeps them and clears bits 7:0. A bus reset with `aux_pwr` low clears them.
- R12: `acc_func` has no effect: a value written while the function select is 1 reads back the same while it is 0, and the reverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low bus reset |
| aux_pwr | input | 1 | Auxiliary power present; keeps sticky bits through reset |
| acc_en | input | 1 | Host access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_func | input | 1 | Originating host function (0 or 1) |
| acc_addr | input | 4 | Offset within the I/O window |
| acc_size16 | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| wdata | input | 16 | Write data; 8-bit writes use bits 7:0 |
| rdata | output | 16 | Read data, combinational from the current access |
| dma_status | input | 16 | Value returned by the DMA status port |
| link_status | input | 16 | Value returned by the link status port |
| hw_val | input | 64 | Hardware values for read-only slots, 16 bits per slot |
| ctrl_q | output | 64 | Stored register contents, 16 bits per slot |

## Verification
The bench aims at the edges of the index range (0Fh, 10h, 13h, 14h). A decoder that is off by one there would make a reserved slot respond, or would drop a real register. Single-byte writes to each lane are compared with a bench model. A wrong lane mask would corrupt the neighbouring byte, or would shift the byte that is read back. The bench also covers:

- the low bits of the descriptor pointer, which must never latch;
- writes to the read-only slot and read-backs of the write-only slot, which would leak stored data if the slot kind were ignored;
- bus resets with auxiliary power both present and absent, which show whether sticky bits are cleared or lost in the wrong case.

A constrained random stream of mixed index, data and status accesses, with changing function selects, then checks that the index is held between data accesses.

// File: rtl/idxbank_pkg.sv
package idxbank_pkg;
   // slot kinds
   localparam logic [1:0] KIND_RW = 2'd0;
   localparam logic [1:0] KIND_RO = 2'd1;
   localparam logic [1:0] KIND_WO = 2'd2;

   // window offsets (data port spans 0h and 1h for byte lanes)
   localparam logic [3:0] OFS_INDEX = 4'h2;
   localparam logic [3:0] OFS_DMA   = 4'h4;
   localparam logic [3:0] OFS_LINK  = 4'hC;

   localparam int unsigned WORD_W = 16;
   localparam int unsigned IDX_W  = 8;
endpackage

// File: rtl/idxbank_decode.sv
module idxbank_decode
   import idxbank_pkg::*;
#(
   parameter int unsigned NUM_REGS = 4,
   parameter logic [7:0]  BASE_IDX = 8'h10
) (
   input  logic [3:0]          acc_addr,
   input  logic                acc_size16,
   input  logic [IDX_W-1:0]    idx_q,
   output logic                is_data,
   output logic                is_index,
   output logic                is_dma,
   output logic                is_link,
   output logic [1:0]          be,
   output logic [NUM_REGS-1:0] hit
);
   localparam int unsigned SPAN_W = IDX_W + 1;

   always_comb begin
      is_data  = (acc_addr[3:1] == 3'b000);
      is_index = (acc_addr == OFS_INDEX);
      is_dma   = (acc_addr == OFS_DMA);
      is_link  = (acc_addr == OFS_LINK);
      if (acc_size16) be = 2'b11;
      else            be = acc_addr[0] ? 2'b10 : 2'b01;
   end

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
      localparam logic [SPAN_W-1:0] SLOT_IDX = SPAN_W'(BASE_IDX) + SPAN_W'(i);
      assign hit[i] = ({1'b0, idx_q} == SLOT_IDX);
   end
endmodule

// File: rtl/idxbank_slot.sv
module idxbank_slot
   import idxbank_pkg::*;
#(
   parameter logic [1:0]        KIND        = KIND_RW,
   parameter logic [WORD_W-1:0] BIT_MASK    = 16'hFFFF,
   parameter logic [WORD_W-1:0] STICKY_MASK = 16'h0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              aux_pwr,
   input  logic              wr_en,
   input  logic [1:0]        be,
   input  logic [WORD_W-1:0] wdata,
   input  logic [WORD_W-1:0] hw_val,
   output logic [WORD_W-1:0] rd_val,
   output logic [WORD_W-1:0] store_q
);
   if (KIND == KIND_RO) begin : g_ro
      assign rd_val  = hw_val & BIT_MASK;
      assign store_q = '0;
   end else begin : g_stored
      logic [WORD_W-1:0] q;
      logic [WORD_W-1:0] wmask;

      assign wmask = BIT_MASK & {{8{be[1]}}, {8{be[0]}}};

      always_ff @(posedge clk) begin
         if (!rst_n)     q <= aux_pwr ? (q & STICKY_MASK & BIT_MASK) : '0;
         else if (wr_en) q <= (q & ~wmask) | (wdata & wmask);
      end

      if (KIND == KIND_WO) begin : g_wo
         assign rd_val = '0;
      end else begin : g_rw
         assign rd_val = q;
      end
      assign store_q = q;
   end
endmodule

// File: rtl/idx_reg_bank.sv
module idx_reg_bank
   import idxbank_pkg::*;
#(
   parameter int unsigned NUM_REGS = 4,
   parameter logic [7:0]  BASE_IDX = 8'h10,
   parameter logic [NUM_REGS-1:0][1:0] SLOT_KIND =
      {KIND_WO, KIND_RO, KIND_RW, KIND_RW},
   parameter logic [NUM_REGS-1:0][15:0] BIT_MASK =
      {16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFF8},
   parameter logic [NUM_REGS-1:0][15:0] STICKY_MASK =
      {16'h0000, 16'h0000, 16'hFF00, 16'h0000},
   localparam int unsigned BUS_W = NUM_REGS * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              aux_pwr,
   input  logic              acc_en,
   input  logic              acc_wr,
   input  logic              acc_func,
   input  logic [3:0]        acc_addr,
   input  logic              acc_size16,
   input  logic [15:0]       wdata,
   output logic [15:0]       rdata,
   input  logic [15:0]       dma_status,
   input  logic [15:0]       link_status,
   input  logic [BUS_W-1:0]  hw_val,
   output logic [BUS_W-1:0]  ctrl_q
);
   // elaboration checks
   if (NUM_REGS < 1) begin : g_bad_num
      $error("idx_reg_bank: NUM_REGS must be at least 1");
   end
   if (int'(BASE_IDX) + NUM_REGS > 256) begin : g_bad_span
      $error("idx_reg_bank: register span exceeds the 8-bit index space");
   end

   logic [IDX_W-1:0]    idx_q;
   logic                is_data, is_index, is_dma, is_link;
   logic [1:0]          be;
   logic [NUM_REGS-1:0] hit;
   logic [WORD_W-1:0]   wdata_al;
   logic [WORD_W-1:0]   rd_val [NUM_REGS];
   logic [WORD_W-1:0]   data_word;
   logic [WORD_W-1:0]   word_out;
   logic                func_unused;

   // both host functions share one register set
   assign func_unused = acc_func;

   idxbank_decode #(.NUM_REGS(NUM_REGS), .BASE_IDX(BASE_IDX)) u_dec (
      .acc_addr   (acc_addr),
      .acc_size16 (acc_size16),
      .idx_q      (idx_q),
      .is_data    (is_data),
      .is_index   (is_index),
      .is_dma     (is_dma),
      .is_link    (is_link),
      .be         (be),
      .hit        (hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                            idx_q <= '0;
      else if (acc_en && acc_wr && is_index) idx_q <= wdata[7:0];
   end

   assign wdata_al = acc_size16 ? wdata : {wdata[7:0], wdata[7:0]};

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
      logic wr_en;
      assign wr_en = acc_en && acc_wr && is_data && hit[i] && (SLOT_KIND[i] != KIND_RO);

      idxbank_slot #(
         .KIND        (SLOT_KIND[i]),
         .BIT_MASK    (BIT_MASK[i]),
         .STICKY_MASK (STICKY_MASK[i])
      ) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .aux_pwr (aux_pwr),
         .wr_en   (wr_en),
         .be      (be),
         .wdata   (wdata_al),
         .hw_val  (hw_val[i*WORD_W +: WORD_W]),
         .rd_val  (rd_val[i]),
         .store_q (ctrl_q[i*WORD_W +: WORD_W])
      );
   end

   always_comb begin
      data_word = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (hit[i]) data_word = data_word | rd_val[i];
      end
   end

   always_comb begin
      if (is_data)       word_out = data_word;
      else if (is_index) word_out = {8'h00, idx_q};
      else if (is_dma)   word_out = dma_status;
      else if (is_link)  word_out = link_status;
      else               word_out = '0;
   end

   always_comb begin
      if (acc_size16)       rdata = word_out;
      else if (acc_addr[0]) rdata = {8'h00, word_out[15:8]};
      else                  rdata = {8'h00, word_out[7:0]};
   end
endmodule

// File: rtl/idx_reg_bank_chk.sv
module idx_reg_bank_chk #(
   parameter int unsigned NUM_REGS = 4,
   parameter logic [7:0]  BASE_IDX = 8'h10,
   localparam int unsigned BUS_W = NUM_REGS * 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             acc_en,
   input logic             acc_wr,
   input logic [3:0]       acc_addr,
   input logic             acc_size16,
   input logic [15:0]      rdata,
   input logic [15:0]      dma_status,
   input logic [15:0]      link_status,
   input logic [7:0]       idx_q,
   input logic [BUS_W-1:0] ctrl_q
);
   logic data_acc, reserved;
   assign data_acc = acc_en && (acc_addr[3:1] == 3'b000);
   assign reserved = ({1'b0, idx_q} < {1'b0, BASE_IDX}) ||
                     ({1'b0, idx_q} >= ({1'b0, BASE_IDX} + 9'(NUM_REGS)));

   // R7
   reserved_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_acc && !acc_wr && reserved) |-> (rdata == 16'h0000));

   // R5
   idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_acc |=> $stable(idx_q));

   // R6
   dma_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !acc_wr && acc_size16 && acc_addr == 4'h4) |-> (rdata == dma_status));

   // R6
   link_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !acc_wr && acc_size16 && acc_addr == 4'hC) |-> (rdata == link_status));

   // R6
   no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(data_acc && acc_wr) |=> $stable(ctrl_q));

   // R8
   dtp_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_acc && acc_wr && idx_q == BASE_IDX) |=> (ctrl_q[2:0] == 3'b000));
endmodule

bind idx_reg_bank idx_reg_bank_chk #(.NUM_REGS(NUM_REGS), .BASE_IDX(BASE_IDX)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .acc_en      (acc_en),
   .acc_wr      (acc_wr),
   .acc_addr    (acc_addr),
   .acc_size16  (acc_size16),
   .rdata       (rdata),
   .dma_status  (dma_status),
   .link_status (link_status),
   .idx_q       (idx_q),
   .ctrl_q      (ctrl_q)
);

// File: tb/test_idx_reg_bank.sv
module test_idx_reg_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        aux_pwr = 1'b0;
   logic        acc_en = 1'b0;
   logic        acc_wr = 1'b0;
   logic        acc_func = 1'b0;
   logic [3:0]  acc_addr = 4'h0;
   logic        acc_size16 = 1'b0;
   logic [15:0] wdata = 16'h0;
   logic [15:0] rdata;
   logic [15:0] dma_status = 16'h0;
   logic [15:0] link_status = 16'h0;
   logic [63:0] hw_val = 64'h0;
   logic [63:0] ctrl_q;

   int n_chk = 0;
   int n_fail = 0;
   logic done = 1'b0;

   // bench model
   logic [15:0] m [4];
   logic [7:0]  m_idx;

   always #2 clk = ~clk;

   idx_reg_bank i_idx_reg_bank (
      .clk(clk), .rst_n(rst_n), .aux_pwr(aux_pwr), .acc_en(acc_en), .acc_wr(acc_wr),
      .acc_func(acc_func), .acc_addr(acc_addr), .acc_size16(acc_size16), .wdata(wdata),
      .rdata(rdata), .dma_status(dma_status), .link_status(link_status),
      .hw_val(hw_val), .ctrl_q(ctrl_q)
   );

   function automatic logic [15:0] slot_mask(input int s);
      case (s)
         0: return 16'hFFF8;
         1: return 16'hFFFF;
         3: return 16'hFFFF;
         default: return 16'h0000;
      endcase
   endfunction

   function automatic logic [15:0] exp_data_word();
      if (m_idx >= 8'h10 && m_idx <= 8'h13) begin
         case (m_idx)
            8'h10: return m[0];
            8'h11: return m[1];
            8'h12: return hw_val[47:32];
            default: return 16'h0000;
         endcase
      end
      return 16'h0000;
   endfunction

   function automatic logic [15:0] exp_read(input logic [3:0] a, input logic s16);
      logic [15:0] w;
      case (a)
         4'h0, 4'h1: w = exp_data_word();
         4'h2:       w = {8'h00, m_idx};
         4'h4:       w = dma_status;
         4'hC:       w = link_status;
         default:    w = 16'h0000;
      endcase
      if (s16) return w;
      return a[0] ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
   endfunction

   function automatic logic [63:0] exp_ctrl();
      return {m[3], 16'h0000, m[1], m[0]};
   endfunction

   task automatic model_write(input logic [3:0] a, input logic s16, input logic [15:0] wd);
      logic [15:0] al, bm;
      int s;
      if (a == 4'h2) m_idx = wd[7:0];
      else if (a[3:1] == 3'b000 && m_idx >= 8'h10 && m_idx <= 8'h13) begin
         s = int'(m_idx - 8'h10);
         al = s16 ? wd : {wd[7:0], wd[7:0]};
         bm = s16 ? 16'hFFFF : (a[0] ? 16'hFF00 : 16'h00FF);
         bm = bm & slot_mask(s);
         m[s] = (m[s] & ~bm) | (al & bm);
      end
   endtask

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic access(input logic wr, input logic fn, input logic [3:0] a,
                         input logic s16, input logic [15:0] wd, output logic [15:0] rd);
      @(negedge clk);
      acc_en = 1'b1; acc_wr = wr; acc_func = fn; acc_addr = a; acc_size16 = s16; wdata = wd;
      #1 rd = rdata;
      @(posedge clk);
      #1 acc_en = 1'b0;
      if (wr) model_write(a, s16, wd);
   endtask

   task automatic wr(input logic [3:0] a, input logic s16, input logic [15:0] wd);
      logic [15:0] d;
      access(1'b1, 1'b0, a, s16, wd, d);
   endtask

   task automatic rd_chk(input string req, input logic fn, input logic [3:0] a, input logic s16);
      logic [15:0] d;
      logic [15:0] e;
      e = exp_read(a, s16);
      access(1'b0, fn, a, s16, 16'h0, d);
      check(req, {48'h0, d}, {48'h0, e});
   endtask

   task automatic bus_reset(input logic aux);
      @(negedge clk);
      aux_pwr = aux; rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      m_idx = 8'h00;
      for (int s = 0; s < 4; s++) m[s] = aux && s == 1 ? (m[s] & 16'hFF00) : 16'h0000;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual running expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      void'($urandom(32'd20240611));
      for (int s = 0; s < 4; s++) m[s] = 16'h0;
      m_idx = 8'h00;
      hw_val = 64'h1357_2468_9ABC_DEF0;
      dma_status = 16'hA5A5;
      link_status = 16'h5A0F;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      check("R1 ctrl_q", ctrl_q, 64'h0);
      rd_chk("R1 index after reset", 1'b0, 4'h2, 1'b1);

      // R2 index write/readback
      wr(4'h2, 1'b0, 16'hFF11);
      rd_chk("R2 index readback", 1'b0, 4'h2, 1'b1);

      // R3 full word, R11 sticky register setup
      wr(4'h0, 1'b1, 16'hABCD);
      rd_chk("R3 word readback", 1'b0, 4'h0, 1'b1);
      check("R3 ctrl_q", ctrl_q, exp_ctrl());

      // R4 byte lanes
      wr(4'h1, 1'b0, 16'h0077);
      rd_chk("R4 upper lane read", 1'b0, 4'h1, 1'b0);
      rd_chk("R4 lower lane untouched", 1'b0, 4'h0, 1'b0);
      wr(4'h0, 1'b0, 16'hEE22);
      check("R4 ctrl_q byte write", ctrl_q, exp_ctrl());
      rd_chk("R4 word after byte writes", 1'b0, 4'h0, 1'b1);

      // R8 descriptor pointer low bits
      wr(4'h2, 1'b0, 16'h0010);
      wr(4'h0, 1'b1, 16'hFFFF);
      rd_chk("R8 low bits read zero", 1'b0, 4'h0, 1'b1);
      check("R8 ctrl_q low bits", {61'h0, ctrl_q[2:0]}, 64'h0);

      // R7 reserved boundaries
      foreach (m[s]) ; // no-op
      wr(4'h2, 1'b0, 16'h000F);
      wr(4'h0, 1'b1, 16'h1234);
      check("R7 write at 0Fh ignored", ctrl_q, exp_ctrl());
      rd_chk("R7 read at 0Fh", 1'b0, 4'h0, 1'b1);
      wr(4'h2, 1'b0, 16'h0014);
      wr(4'h0, 1'b1, 16'h4321);
      check("R7 write at 14h ignored", ctrl_q, exp_ctrl());
      rd_chk("R7 read at 14h", 1'b0, 4'h0, 1'b1);
      wr(4'h2, 1'b0, 16'h0005);
      rd_chk("R7 read at 05h", 1'b0, 4'h1, 1'b0);

      // R9 read-only slot
      wr(4'h2, 1'b0, 16'h0012);
      wr(4'h0, 1'b1, 16'hFFFF);
      rd_chk("R9 read-only value", 1'b0, 4'h0, 1'b1);
      check("R9 ctrl_q unchanged", ctrl_q, exp_ctrl());

      // R10 write-only slot
      wr(4'h2, 1'b0, 16'h0013);
      wr(4'h0, 1'b1, 16'hC0DE);
      rd_chk("R10 write-only reads zero", 1'b0, 4'h0, 1'b1);
      check("R10 ctrl_q carries value", ctrl_q, exp_ctrl());

      // R6 status ports and unmapped offsets
      rd_chk("R6 dma status", 1'b0, 4'h4, 1'b1);
      rd_chk("R6 link status", 1'b1, 4'hC, 1'b1);
      rd_chk("R6 unmapped offset 8h", 1'b0, 4'h8, 1'b1);
      wr(4'h4, 1'b1, 16'hFFFF);
      wr(4'hC, 1'b1, 16'hFFFF);
      check("R6 status writes ignored", ctrl_q, exp_ctrl());

      // R12 cross-function sharing
      wr(4'h2, 1'b0, 16'h0011);
      access(1'b1, 1'b1, 4'h0, 1'b1, 16'h6B2C, d);
      rd_chk("R12 func1 write seen by func0", 1'b0, 4'h0, 1'b1);
      access(1'b1, 1'b0, 4'h1, 1'b0, 16'h0039, d);
      rd_chk("R12 func0 write seen by func1", 1'b1, 4'h0, 1'b1);

      // R11 sticky with and without aux power
      bus_reset(1'b1);
      check("R11 sticky kept with aux", ctrl_q, exp_ctrl());
      wr(4'h2, 1'b0, 16'h0011);
      rd_chk("R11 sticky readback", 1'b0, 4'h0, 1'b1);
      bus_reset(1'b0);
      check("R11 sticky lost without aux", ctrl_q, 64'h0);
      check("R1 ctrl_q after reset", ctrl_q, exp_ctrl());

      // constrained random mix, R5 index held between data accesses
      for (int k = 0; k < 400; k++) begin
         int op;
         logic [3:0] a;
         logic s16, fn;
         logic [15:0] wd;
         op  = $urandom_range(0, 9);
         s16 = 1'($urandom_range(0, 1));
         fn  = 1'($urandom_range(0, 1));
         wd  = 16'($urandom);
         if (k % 20 == 0) begin
            hw_val = {$urandom, $urandom};
            dma_status = 16'($urandom);
            link_status = 16'($urandom);
         end
         if (op == 0) begin
            wr(4'h2, 1'b0, {8'h00, 8'($urandom_range(8'h0E, 8'h15))});
         end else if (op <= 4) begin
            a = {3'b000, 1'($urandom_range(0, 1))};
            access(1'b1, fn, a, s16, wd, d);
            check("R5 ctrl_q after data write", ctrl_q, exp_ctrl());
         end else if (op <= 8) begin
            a = {3'b000, 1'($urandom_range(0, 1))};
            rd_chk("R5 data read", fn, a, s16);
         end else begin
            a = 4'($urandom_range(2, 15));
            rd_chk("R6 window read", fn, a, 1'b1);
         end
      end
      rd_chk("R5 index at end", 1'b0, 4'h2, 1'b1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule